// File: doc/BRIEF.md
# Eight-Input Priority Interrupt Controller

This core gathers up to eight interrupt request lines and drives a single interrupt output toward a processor. Each line is captured into a request register, either on a rising edge or as a live level. A mask register hides chosen lines. An in-service register records the levels the processor is handling now. A fixed-priority resolver makes line 0 the most urgent and line 7 the least. The resolver raises the output only when an unmasked pending line beats every level already in service, so service is fully nested.

The processor reaches the core through a small register port. This port has a chip select, a one-bit address, read and write strobes and an 8-bit data bus. At address 1 it writes and reads the mask. At address 0 it issues commands and reads back whichever register the last select command picked. A one-cycle acknowledge pulse moves the winning request into service. A non-specific end-of-interrupt command retires the most urgent level in service.

Top module: `pic8_core`

## Requirements
- R1: After reset the request, in-service and mask registers are all zero, `int_out` is low, capture is edge mode, and an address-0 read returns the request register.
- R2: In edge mode a rising edge on `irq_in[i]` sets request bit i at the next clock edge. The bit stays set after the input falls, until an acknowledge takes that level.
- R3: In level mode each request bit equals the value `irq_in` had at the previous clock edge. This also holds right after an acknowledge.
- R4: A write with `bus_addr`=1 loads the mask from `bus_wdata`, and a read with `bus_addr`=1 returns it. A masked line is still recorded in the request register but never raises `int_out`. The other lines are not affected.
- R5: `int_out` is high exactly when some unmasked request bit has a lower index than every set in-service bit, or when such a bit exists and nothing is in service. Requests of equal or lower priority are held back. `int_out` follows a state change at the same clock edge as that change.
- R6: When `int_ack` is high at a clock edge and `int_out` is high, the lowest-index unmasked request moves into service: its in-service bit sets and, in edge mode, its request bit clears. An acknowledge with nothing qualifying changes nothing.
- R7: Writing 0x20 at address 0 is the end-of-interrupt command. It clears only the lowest-index set in-service bit.
- R8: Writing 0x60, 0x61 or 0x62 at address 0 makes later address-0 reads return the request, in-service or mask register, in that order. Read data appears on `bus_rdata` at the clock edge where the read strobe is sampled, and it holds until the next read.
- R9: Writing 0x41 at address 0 selects level mode, and writing 0x40 selects edge mode.
- R10: Strobes are ignored while `bus_sel` is low. The mask is unchanged, and so is every other register.
- R11: When IR6 is in service and IR3 arrives, `int_out` rises again. After acknowledge the in-service register reads 0x48.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 8 | Interrupt request lines, bit 0 most urgent |
| bus_sel | input | 1 | Chip select, active high |
| bus_addr | input | 1 | Port select: 0 command/readback, 1 mask |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| int_ack | input | 1 | Interrupt acknowledge pulse |
| int_out | output | 1 | Registered interrupt request to the processor |

## Verification
A wrong in-service bit shows up at `int_out` straight away. A stale high bit holds back a request that should fire. A missing bit lets an equal-priority request fire again, one clock edge after the acknowledge or end-of-interrupt that set the state. Request and mask corruption show up on the next readback through the selected port. The bench also drives `int_out` patterns in level mode against mask values, and it follows a nested IR6/IR3/IR5 sequence through acknowledges and end-of-interrupt commands.

// File: rtl/pic8_pkg.sv
package pic8_pkg;

  // Command opcode in write data bits [7:5] at address 0
  localparam logic [2:0] OP_EOI  = 3'b001;
  localparam logic [2:0] OP_MODE = 3'b010;
  localparam logic [2:0] OP_RSEL = 3'b011;

  typedef enum logic [1:0] {
    RS_REQ  = 2'd0,
    RS_ISR  = 2'd1,
    RS_MASK = 2'd2,
    RS_REQ2 = 2'd3
  } rsel_t;

  typedef struct packed {
    logic  eoi;
    logic  mode_wr;
    logic  mode_level;
    logic  rsel_wr;
    rsel_t rsel;
    logic  mask_wr;
  } cmd_t;

endpackage

// File: rtl/pic8_prio_pick.sv
module pic8_prio_pick #(
  parameter int N  = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  vec,
  output logic          found,
  output logic [IW-1:0] idx,
  output logic [N-1:0]  onehot
);

  // Lowest set index wins; bit 0 has the highest priority.
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end

  assign onehot = vec & (~vec + N'(1));

endmodule

// File: rtl/pic8_req_capture.sv
module pic8_req_capture #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         level_mode,
  input  logic [N-1:0] irq_in,
  input  logic [N-1:0] clr_onehot,
  output logic [N-1:0] req_q,
  output logic [N-1:0] req_d
);

  logic [N-1:0] prev_q;
  logic [N-1:0] rise;

  assign rise = irq_in & ~prev_q;

  always_comb begin
    if (level_mode) req_d = irq_in;
    else            req_d = (req_q & ~clr_onehot) | rise;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q  <= '0;
      prev_q <= '0;
    end else begin
      req_q  <= req_d;
      prev_q <= irq_in;
    end
  end

  AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (rst)
    (!level_mode && clr_onehot == '0) |=> ((req_q & $past(req_q)) == $past(req_q))); // R2

  AST_LEVEL_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    level_mode |=> (req_q == $past(irq_in))); // R3

endmodule

// File: rtl/pic8_host_port.sv
module pic8_host_port
  import pic8_pkg::*;
#(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         bus_sel,
  input  logic         bus_addr,
  input  logic         bus_rd,
  input  logic         bus_wr,
  input  logic [7:0]   bus_wdata,
  input  logic [N-1:0] req_q,
  input  logic [N-1:0] isr_q,
  output logic [7:0]   bus_rdata,
  output cmd_t         cmd,
  output logic [N-1:0] mask_q,
  output logic [N-1:0] mask_d,
  output logic         level_mode
);

  rsel_t      rsel_q;
  logic       wr_hit;
  logic       rd_hit;
  logic [7:0] rd_mux;

  assign wr_hit = bus_sel & bus_wr;
  assign rd_hit = bus_sel & bus_rd;

  always_comb begin
    cmd            = '0;
    cmd.mask_wr    = wr_hit & bus_addr;
    cmd.mode_level = bus_wdata[0];
    cmd.rsel       = rsel_t'(bus_wdata[1:0]);
    if (wr_hit && !bus_addr) begin
      cmd.eoi     = (bus_wdata[7:5] == OP_EOI);
      cmd.mode_wr = (bus_wdata[7:5] == OP_MODE);
      cmd.rsel_wr = (bus_wdata[7:5] == OP_RSEL);
    end
  end

  assign mask_d = cmd.mask_wr ? bus_wdata[N-1:0] : mask_q;

  always_comb begin
    rd_mux = '0;
    if (bus_addr) begin
      rd_mux[N-1:0] = mask_q;
    end else begin
      case (rsel_q)
        RS_ISR:  rd_mux[N-1:0] = isr_q;
        RS_MASK: rd_mux[N-1:0] = mask_q;
        default: rd_mux[N-1:0] = req_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q     <= '0;
      level_mode <= 1'b0;
      rsel_q     <= RS_REQ;
      bus_rdata  <= '0;
    end else begin
      mask_q <= mask_d;
      if (cmd.mode_wr) level_mode <= cmd.mode_level;
      if (cmd.rsel_wr) rsel_q     <= cmd.rsel;
      if (rd_hit)      bus_rdata  <= rd_mux;
    end
  end

  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && bus_wr && bus_addr) |=> (mask_q == $past(bus_wdata[N-1:0]))); // R4

  AST_NOSEL_HOLD: assert property (@(posedge clk) disable iff (rst)
    !bus_sel |=> ($stable(mask_q) && $stable(bus_rdata) && $stable(level_mode))); // R10

endmodule

// File: rtl/pic8_core.sv
module pic8_core
  import pic8_pkg::*;
#(
  parameter int NUM_IRQ = 8,
  localparam int IW = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_IRQ-1:0] irq_in,
  input  logic               bus_sel,
  input  logic               bus_addr,
  input  logic               bus_rd,
  input  logic               bus_wr,
  input  logic [7:0]         bus_wdata,
  output logic [7:0]         bus_rdata,
  input  logic               int_ack,
  output logic               int_out
);

  cmd_t               cmd;
  logic [NUM_IRQ-1:0] mask_q, mask_d;
  logic               level_mode;
  logic [NUM_IRQ-1:0] req_q, req_d;
  logic [NUM_IRQ-1:0] isr_q, isr_d;
  logic [NUM_IRQ-1:0] ack_set, eoi_clr;
  logic               ack_take;

  // Current-state resolver outputs (drive acknowledge and end-of-interrupt)
  logic               win_f, top_f;
  logic [IW-1:0]      win_i, top_i;
  logic [NUM_IRQ-1:0] win_oh, top_oh;
  // Next-state resolver outputs (drive the registered interrupt line)
  logic               nwin_f, ntop_f;
  logic [IW-1:0]      nwin_i, ntop_i;
  logic [NUM_IRQ-1:0] nwin_oh, ntop_oh;
  logic               int_d;

  pic8_host_port #(.N(NUM_IRQ)) u_port (
    .clk(clk), .rst(rst),
    .bus_sel(bus_sel), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .req_q(req_q), .isr_q(isr_q),
    .bus_rdata(bus_rdata), .cmd(cmd), .mask_q(mask_q), .mask_d(mask_d),
    .level_mode(level_mode)
  );

  pic8_req_capture #(.N(NUM_IRQ)) u_cap (
    .clk(clk), .rst(rst), .level_mode(level_mode), .irq_in(irq_in),
    .clr_onehot(ack_set), .req_q(req_q), .req_d(req_d)
  );

  pic8_prio_pick #(.N(NUM_IRQ)) u_win (
    .vec(req_q & ~mask_q), .found(win_f), .idx(win_i), .onehot(win_oh));

  pic8_prio_pick #(.N(NUM_IRQ)) u_top (
    .vec(isr_q), .found(top_f), .idx(top_i), .onehot(top_oh));

  pic8_prio_pick #(.N(NUM_IRQ)) u_nwin (
    .vec(req_d & ~mask_d), .found(nwin_f), .idx(nwin_i), .onehot(nwin_oh));

  pic8_prio_pick #(.N(NUM_IRQ)) u_ntop (
    .vec(isr_d), .found(ntop_f), .idx(ntop_i), .onehot(ntop_oh));

  // A request qualifies only if it beats every level in service.
  assign ack_take = int_ack && win_f && (!top_f || (win_i < top_i));
  assign ack_set  = ack_take ? win_oh : '0;
  assign eoi_clr  = cmd.eoi ? top_oh : '0;
  assign isr_d    = (isr_q & ~eoi_clr) | ack_set;
  assign int_d    = nwin_f && (!ntop_f || (nwin_i < ntop_i));

  always_ff @(posedge clk) begin
    if (rst) begin
      isr_q   <= '0;
      int_out <= 1'b0;
    end else begin
      isr_q   <= isr_d;
      int_out <= int_d;
    end
  end

  AST_INT_NEEDS_PENDING: assert property (@(posedge clk) disable iff (rst)
    int_out |-> ((req_q & ~mask_q) != '0)); // R5

  AST_NESTED_GATE: assert property (@(posedge clk) disable iff (rst)
    (int_out && top_f) |-> (win_f && (win_i < top_i))); // R5

  AST_ACK_GROWS: assert property (@(posedge clk) disable iff (rst)
    (ack_take && !cmd.eoi) |=> ($countones(isr_q) == $countones($past(isr_q)) + 1)); // R6

  AST_EOI_SHRINKS: assert property (@(posedge clk) disable iff (rst)
    (cmd.eoi && !int_ack && isr_q != '0) |=> ($countones(isr_q) + 1 == $countones($past(isr_q)))); // R7

  AST_IDLE_ACK_NOP: assert property (@(posedge clk) disable iff (rst)
    (int_ack && !int_out && !cmd.eoi) |=> $stable(isr_q)); // R6

endmodule

// File: tb/pic8_core_tb_top.sv
module pic8_core_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] irq_in = '0;
  logic       bus_sel = 1'b0, bus_addr = 1'b0, bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       int_ack = 1'b0;
  logic       int_out;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #10 clk = ~clk; // 50 MHz

  pic8_core dut_i (
    .clk(clk), .rst(rst), .irq_in(irq_in),
    .bus_sel(bus_sel), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .int_ack(int_ack), .int_out(int_out)
  );

  // {irq, mask, expected int_out} walked in level mode with nothing in service
  localparam logic [16:0] LVL_VEC [7] = '{
    {8'h00, 8'h00, 1'b0},
    {8'h80, 8'h00, 1'b1},
    {8'h80, 8'h80, 1'b0},
    {8'h81, 8'h80, 1'b1},
    {8'hFF, 8'hFF, 1'b0},
    {8'h10, 8'hEF, 1'b1},
    {8'h00, 8'h00, 1'b0}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic a, input logic [7:0] d, input logic sel = 1'b1);
    @(negedge clk);
    bus_sel = sel; bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_sel = 1'b0; bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic read_sel(input logic [1:0] s, output logic [7:0] d);
    bus_write(1'b0, {6'b011000, s});
    bus_read(1'b0, d);
  endtask

  task automatic edge_pulse(input logic [7:0] lines);
    @(negedge clk); irq_in = lines;
    @(negedge clk); irq_in = '0;
  endtask

  task automatic ack;
    @(negedge clk); int_ack = 1'b1;
    @(negedge clk); int_ack = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check("R1 int", {7'b0, int_out}, 8'h00);
    bus_read(1'b0, rd); check("R1 default read is request", rd, 8'h00);
    bus_read(1'b1, rd); check("R1 mask", rd, 8'h00);
    read_sel(2'd1, rd); check("R1 isr", rd, 8'h00);
    bus_write(1'b0, 8'h60);

    // R2 edge capture, R11 nesting IR6 then IR3
    edge_pulse(8'h40);
    check("R2 int after IR6 edge", {7'b0, int_out}, 8'h01);
    bus_read(1'b0, rd); check("R2 sticky request", rd, 8'h40);
    ack;
    check("R6 int drops after ack", {7'b0, int_out}, 8'h00);
    read_sel(2'd1, rd); check("R6 isr IR6", rd, 8'h40);
    read_sel(2'd0, rd); check("R6 request cleared", rd, 8'h00);
    edge_pulse(8'h08);
    check("R11 int for IR3 over IR6", {7'b0, int_out}, 8'h01);
    ack;
    read_sel(2'd1, rd); check("R11 isr 0x48", rd, 8'h48);

    // R5 lower priority held; R7 EOI order
    edge_pulse(8'h20);
    check("R5 IR5 held behind IR3", {7'b0, int_out}, 8'h00);
    bus_write(1'b0, 8'h20);
    check("R5 IR5 fires above IR6", {7'b0, int_out}, 8'h01);
    bus_read(1'b0, rd); check("R7 EOI cleared IR3 only", rd, 8'h40);
    ack;
    bus_read(1'b0, rd); check("R6 isr 0x60", rd, 8'h60);
    bus_write(1'b0, 8'h20);
    bus_read(1'b0, rd); check("R7 EOI cleared IR5", rd, 8'h40);
    bus_write(1'b0, 8'h20);
    bus_read(1'b0, rd); check("R7 isr empty", rd, 8'h00);

    // R6 ack with nothing pending
    ack;
    bus_read(1'b0, rd); check("R6 idle ack ignored", rd, 8'h00);

    // R4 mask hides IR0, R8 mask via address 0
    bus_write(1'b1, 8'h01);
    edge_pulse(8'h01);
    check("R4 masked no int", {7'b0, int_out}, 8'h00);
    read_sel(2'd2, rd); check("R8 mask via select", rd, 8'h01);
    read_sel(2'd0, rd); check("R4 masked still requested", rd, 8'h01);
    bus_write(1'b1, 8'h00);
    check("R4 unmask raises int", {7'b0, int_out}, 8'h01);
    ack;
    read_sel(2'd1, rd); check("R6 isr IR0", rd, 8'h01);
    bus_write(1'b0, 8'h20);
    bus_read(1'b0, rd); check("R7 isr clear", rd, 8'h00);
    bus_write(1'b0, 8'h60);

    // R10 writes without select ignored
    bus_write(1'b1, 8'hFF, 1'b0);
    bus_read(1'b1, rd); check("R10 mask unchanged", rd, 8'h00);

    // R9 level mode, R3 table walk
    bus_write(1'b0, 8'h41);
    for (int k = 0; k < 7; k++) begin
      bus_write(1'b1, LVL_VEC[k][8:1]);
      @(negedge clk); irq_in = LVL_VEC[k][16:9];
      @(negedge clk);
      check("R3/R4 level int", {7'b0, int_out}, {7'b0, LVL_VEC[k][0]});
      bus_read(1'b0, rd); check("R3 level request", rd, LVL_VEC[k][16:9]);
    end

    // R3 level request re-evaluated after ack; equal level held
    @(negedge clk); irq_in = 8'h04;
    @(negedge clk);
    ack;
    bus_read(1'b0, rd); check("R3 request kept by level", rd, 8'h04);
    check("R5 equal level held", {7'b0, int_out}, 8'h00);
    bus_write(1'b0, 8'h20);
    check("R5 level re-fires after EOI", {7'b0, int_out}, 8'h01);
    @(negedge clk); irq_in = 8'h00;
    @(negedge clk);
    check("R3 level drop clears int", {7'b0, int_out}, 8'h00);
    bus_write(1'b0, 8'h40);
    edge_pulse(8'h02);
    bus_read(1'b0, rd); check("R9 back to edge sticky", rd, 8'h02);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule